// File: doc/BRIEF.md
# LCD Scanline Mode Timing Generator

This block produces the raster timing of a small LCD controller from one dot clock and a single enable. A dot counter runs across each 456-dot line and a line counter steps through 154 lines per frame. A frame is 70224 dots long. Lines 0 to 143 are visible, and each visible line passes through three phases in a fixed order: object search, then pixel transfer, then horizontal blank. Lines 144 to 153 make up the vertical-blank period.

The block reports the current two-bit mode, the line number and the dot position. It also raises one-cycle strobes when a mode is entered and when the line number changes. Other blocks use the mode to decide which memories the host may access. They use the strobes to raise interrupts or to start pixel fetches. Dropping the enable parks the counters at zero and reports horizontal blank. Raising the enable again restarts the frame at line 0 in object search.

Top module: `lcd_raster_timer`

## Requirements
- R1: `dot_pos` runs from 0 to 455 while enabled. It advances by one each cycle and returns to 0 after 455, so every line lasts 456 cycles.
- R2: `line_idx` advances by one in the cycle after dot 455. It wraps from 153 to 0, so one frame lasts 70224 cycles.
- R3: On lines 0 to 143, `mode` is 2'b10 (object search) for dots 0 to 79, 2'b11 (transfer) for dots 80 to 251 and 2'b00 (horizontal blank) for dots 252 to 455.
- R4: On lines 144 to 153, `mode` is 2'b01 (vertical blank) for every dot.
- R5: When `enable` is sampled low at a clock edge, the next cycle shows `dot_pos` = 0, `line_idx` = 0, `mode` = 2'b00 and all strobes low. This holds for as long as `enable` stays low.
- R6: The first edge that samples `enable` high after it was low starts line 0 at dot 0 in mode 2'b10. Counting continues from the following edge.
- R7: `search_start`, `xfer_start`, `hblank_start` and `vblank_start` are each high for exactly the first cycle of their mode while running. They are at dots 0, 80 and 252 of a visible line and at dot 0 of line 144. At most one of them is high in any cycle.
- R8: `line_step` is high for exactly the first cycle in which `line_idx` holds a new value, including the wrap from 153 to 0. It is not raised by a restart after `enable` was low.
- R9: During reset (`rst_n` low, active low, asynchronous), the outputs show the same idle state as R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Controller on when high |
| mode | output | 2 | 00 hblank, 01 vblank, 10 object search, 11 transfer |
| line_idx | output | 8 | Current line, 0 to 153 |
| dot_pos | output | 9 | Dot position within the line, 0 to 455 |
| search_start | output | 1 | First cycle of object search |
| xfer_start | output | 1 | First cycle of transfer |
| hblank_start | output | 1 | First cycle of horizontal blank |
| vblank_start | output | 1 | First cycle of vertical blank |
| line_step | output | 1 | First cycle of a new line number |

## Verification
The assertions check on every cycle that the line number stays in range, that vertical-blank lines always report mode 1, that the visible modes only move forward in order, and that at most one entry strobe is high. They also check that a low enable parks the outputs and that a transfer strobe always follows object search. Only the bench's scenarios can show the exact dot budgets, the full 70224-cycle frame with its wrap from 153 to 0, and a mid-line disable followed by a restart. It compares the outputs cycle by cycle against a model built from the dot count since restart.

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer #(
  parameter int LINE_DOTS     = 456,
  parameter int SEARCH_DOTS   = 80,
  parameter int XFER_DOTS     = 172,
  parameter int VISIBLE_LINES = 144,
  parameter int BLANK_LINES   = 10,
  parameter int DOT_W         = $clog2(LINE_DOTS),
  parameter int LY_W          = $clog2(VISIBLE_LINES + BLANK_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  output logic [1:0]       mode,
  output logic [LY_W-1:0]  line_idx,
  output logic [DOT_W-1:0] dot_pos,
  output logic             search_start,
  output logic             xfer_start,
  output logic             hblank_start,
  output logic             vblank_start,
  output logic             line_step
);

  localparam int TOTAL_LINES = VISIBLE_LINES + BLANK_LINES;
  localparam int XFER_END    = SEARCH_DOTS + XFER_DOTS;

  localparam logic [1:0] M_HBLANK = 2'b00;
  localparam logic [1:0] M_VBLANK = 2'b01;
  localparam logic [1:0] M_SEARCH = 2'b10;
  localparam logic [1:0] M_XFER   = 2'b11;

  logic             run_q, fresh_q;
  logic [DOT_W-1:0] dot_q;
  logic [LY_W-1:0]  ly_q;

  wire last_dot  = dot_q == DOT_W'(LINE_DOTS - 1);
  wire last_line = ly_q == LY_W'(TOTAL_LINES - 1);
  wire in_vblank = ly_q >= LY_W'(VISIBLE_LINES);
  wire line_head = run_q && dot_q == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      fresh_q <= 1'b0;
      dot_q   <= '0;
      ly_q    <= '0;
    end else if (!enable) begin
      run_q   <= 1'b0;
      fresh_q <= 1'b0;
      dot_q   <= '0;
      ly_q    <= '0;
    end else if (!run_q) begin
      run_q   <= 1'b1;
      fresh_q <= 1'b1;
      dot_q   <= '0;
      ly_q    <= '0;
    end else begin
      fresh_q <= 1'b0;
      if (last_dot) begin
        dot_q <= '0;
        ly_q  <= last_line ? '0 : ly_q + 1'b1;
      end else begin
        dot_q <= dot_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (!run_q)                          mode = M_HBLANK;
    else if (in_vblank)                  mode = M_VBLANK;
    else if (dot_q < DOT_W'(SEARCH_DOTS)) mode = M_SEARCH;
    else if (dot_q < DOT_W'(XFER_END))    mode = M_XFER;
    else                                 mode = M_HBLANK;
  end

  assign line_idx     = ly_q;
  assign dot_pos      = dot_q;
  assign search_start = line_head && !in_vblank;
  assign xfer_start   = run_q && !in_vblank && dot_q == DOT_W'(SEARCH_DOTS);
  assign hblank_start = run_q && !in_vblank && dot_q == DOT_W'(XFER_END);
  assign vblank_start = line_head && ly_q == LY_W'(VISIBLE_LINES);
  assign line_step    = line_head && !fresh_q;

endmodule

module lcd_raster_timer_chk #(
  parameter int DOT_W = 9,
  parameter int LY_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [1:0]       mode,
  input logic [LY_W-1:0]  line_idx,
  input logic [DOT_W-1:0] dot_pos,
  input logic             search_start,
  input logic             xfer_start,
  input logic             hblank_start,
  input logic             vblank_start,
  input logic             line_step
);

  a_r2_line_range: assert property (@(posedge clk) disable iff (!rst_n)
    line_idx <= LY_W'(153));

  a_r1_dot_range: assert property (@(posedge clk) disable iff (!rst_n)
    dot_pos <= DOT_W'(455));

  a_r4_vblank_mode: assert property (@(posedge clk) disable iff (!rst_n)
    line_idx >= LY_W'(144) |-> mode == 2'b01);

  a_r3_search_next: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && enable) |=> (mode == 2'b10 || mode == 2'b11));

  a_r3_xfer_next: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && enable) |=> (mode == 2'b11 || mode == 2'b00));

  a_r7_one_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({search_start, xfer_start, hblank_start, vblank_start}));

  a_r7_xfer_after_search: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> ($past(mode) == 2'b10 && mode == 2'b11));

  a_r5_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (mode == 2'b00 && line_idx == '0 && dot_pos == '0 &&
                 !search_start && !xfer_start && !hblank_start &&
                 !vblank_start && !line_step));

  a_r8_step_changes: assert property (@(posedge clk) disable iff (!rst_n)
    line_step |-> line_idx != $past(line_idx));

endmodule

bind lcd_raster_timer lcd_raster_timer_chk #(.DOT_W(DOT_W), .LY_W(LY_W)) chk_i (.*);

// File: tb/lcd_raster_timer_tb_top.sv
module lcd_raster_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] mode;
  logic [7:0] line_idx;
  logic [8:0] dot_pos;
  logic       search_start, xfer_start, hblank_start, vblank_start, line_step;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic [1:0] mode;
    int         ly;
    int         dot;
    logic [4:0] stb;
  } exp_t;

  exp_t exp_q[$];

  always #4 clk = ~clk;

  lcd_raster_timer dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
    .line_idx(line_idx), .dot_pos(dot_pos), .search_start(search_start),
    .xfer_start(xfer_start), .hblank_start(hblank_start),
    .vblank_start(vblank_start), .line_step(line_step)
  );

  bit m_run = 0;
  bit m_fresh = 0;
  int m_c = 0;

  task automatic step(input bit en);
    exp_t e;
    int d, l;
    @(negedge clk);
    enable = en;
    if (!en) begin
      m_run = 0; m_fresh = 0; m_c = 0;
    end else if (!m_run) begin
      m_run = 1; m_fresh = 1; m_c = 0;
    end else begin
      m_fresh = 0; m_c++;
    end
    d = m_c % 456;
    l = (m_c / 456) % 154;
    e.dot = m_run ? d : 0;
    e.ly  = m_run ? l : 0;
    if (!m_run)        e.mode = 2'b00;
    else if (l >= 144) e.mode = 2'b01;
    else if (d < 80)   e.mode = 2'b10;
    else if (d < 252)  e.mode = 2'b11;
    else               e.mode = 2'b00;
    e.stb[4] = m_run && l < 144 && d == 0;
    e.stb[3] = m_run && l < 144 && d == 80;
    e.stb[2] = m_run && l < 144 && d == 252;
    e.stb[1] = m_run && l == 144 && d == 0;
    e.stb[0] = m_run && !m_fresh && d == 0;
    exp_q.push_back(e);
  endtask

  task automatic run_steps(input bit en, input int n);
    for (int i = 0; i < n; i++) step(en);
  endtask

  always begin
    @(posedge clk);
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      logic [4:0] got;
      bit bad;
      e = exp_q.pop_front();
      got = {search_start, xfer_start, hblank_start, vblank_start, line_step};
      bad = 0;
      n_cmp++;
      if (mode !== e.mode) begin
        bad = 1;
        if (n_bad < 20) $display("FAIL R3/R4/R5 mode: got %b expected %b (ly %0d dot %0d)", mode, e.mode, e.ly, e.dot);
      end
      if (int'(line_idx) != e.ly) begin
        bad = 1;
        if (n_bad < 20) $display("FAIL R2/R6 line_idx: got %0d expected %0d", line_idx, e.ly);
      end
      if (int'(dot_pos) != e.dot) begin
        bad = 1;
        if (n_bad < 20) $display("FAIL R1/R6 dot_pos: got %0d expected %0d", dot_pos, e.dot);
      end
      if (got !== e.stb) begin
        bad = 1;
        if (n_bad < 20) $display("FAIL R7/R8 strobes: got %b expected %b (ly %0d dot %0d)", got, e.stb, e.ly, e.dot);
      end
      if (bad) n_bad++;
    end
  end

  initial begin
    #200000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: idle outputs during reset
    n_cmp++;
    if (mode !== 2'b00 || line_idx !== 8'd0 || dot_pos !== 9'd0 ||
        {search_start, xfer_start, hblank_start, vblank_start, line_step} !== 5'b0) begin
      n_bad++;
      $display("FAIL R9 reset: got mode %b ly %0d dot %0d expected 00 0 0", mode, line_idx, dot_pos);
    end
    rst_n = 1'b1;
    run_steps(1'b0, 4);            // R5 idle while disabled
    run_steps(1'b1, 70224 + 1000); // R1 R2 R3 R4 R6 R7 R8 full frame and wrap
    run_steps(1'b0, 6);            // R5 mid-line disable
    run_steps(1'b1, 600);          // R6 restart without line_step at head
    run_steps(1'b0, 1);
    run_steps(1'b1, 460);
    @(negedge clk);
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule